// File: doc/BRIEF.md
# NAND Page-Read Sequencer

This block runs the read side of an 8-bit multiplexed NAND flash bus. A single shared byte lane carries commands, addresses and data, and the command-latch and address-latch enables mark which kind of byte is on the lane. The block takes one request at a time. A request asks for either an identification read or a full page read. The block produces the whole pin sequence for that request, and the bytes it reads leave on a valid/ready byte stream.

A page read sends command 00h, then five address bytes cut from a 28-bit flash address, then command 30h. The block then waits for the device to go busy and come back ready. After that it reads 2048 data bytes, which are forwarded, and 64 spare bytes, which are dropped. An identification read sends 90h and one 00h address byte, then forwards five bytes. Three clock-cycle fields set the bus timing: latch setup before the strobe, strobe width, and hold after the strobe. An enable input gates the acceptance of requests. A force input drives the chip-enable pin.

Top module: `nand_page_reader`

## Requirements
- R1: After reset, nWE and nRE are high, CLE and ALE are low, the byte lane is not driven, no stream byte is valid, the block is not busy, and req_ready equals ctl_en.
- R2: Command bytes go out with CLE=1, ALE=0. Address bytes go out with ALE=1, CLE=0. The lane, CLE and ALE do not change while nWE is low. The lane is driven only while CLE or ALE is high.
- R3: A page read (req_id=0) writes, in this order: command 00h, address bytes addr[7:0], {5'b0,addr[10:8]}, addr[18:11], addr[26:19], {7'b0,addr[27]}, then command 30h.
- R4: For each write byte, the latch enable is high with nWE high for t_setup clocks before nWE falls. nWE stays low for t_strobe+1 clocks. The latch enable stays high with nWE high for t_hold+1 clocks after nWE rises. Each nRE pulse is low for t_strobe+1 clocks and is followed by at least t_hold+1 high clocks.
- R5: After 30h, no nRE pulse starts until the synchronised R/nB has been seen low (busy) and then high (ready). rb_status shows R/nB after two clocks of synchronisation, with 1 meaning ready.
- R6: A page read delivers exactly 2048 stream bytes, in page order. Each byte is the lane value captured when nRE rises. A valid byte and its data stay unchanged until dout_ready is seen.
- R7: After the 2048 data bytes, a page read makes exactly 64 more nRE pulses, puts out no stream byte for them, and then returns to idle.
- R8: An identification read (req_id=1) writes command 90h, then address byte 00h. It makes no busy wait and delivers exactly five stream bytes.
- R9: While ctl_en is 0, req_ready is 0 and any request has no effect on the bus.
- R10: A request is taken only when req_valid and req_ready are both high. While busy, req_ready is 0, and requests made then are dropped without a trace on the bus.
- R11: nf_ce_n equals ce_release: 0 drives chip enable low, 1 drives it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_en | input | 1 | Controller enable; gates request acceptance |
| ce_release | input | 1 | Chip-enable force: 0 drives nCE low, 1 high |
| t_setup | input | 4 | Latch setup clocks before the write strobe |
| t_strobe | input | 4 | Strobe low time minus one, in clocks |
| t_hold | input | 4 | Hold time after strobe minus one, in clocks |
| req_valid | input | 1 | Request strobe |
| req_id | input | 1 | 1 = identification read, 0 = page read |
| req_addr | input | 28 | Flash byte address for page read |
| req_ready | output | 1 | Request can be taken this cycle |
| op_busy | output | 1 | An operation is in progress |
| rb_status | output | 1 | Synchronised R/nB, 1 = ready |
| dout_data | output | 8 | Stream byte |
| dout_valid | output | 1 | Stream byte valid |
| dout_ready | input | 1 | Stream consumer ready |
| nf_io_out | output | 8 | Byte lane, outgoing value |
| nf_io_oe | output | 1 | Byte lane output enable |
| nf_io_in | input | 8 | Byte lane, incoming value |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_rb | input | 1 | Ready/busy from the device, 1 = ready |

## Verification
A request is taken at the clock edge after req_valid is driven, and op_busy is high from that edge on. Bus pins change one edge after a state change, so the bench measures setup, strobe and hold lengths by counting falling-edge samples and compares the counts with t_setup, t_strobe+1 and t_hold+1. The flash model changes the lane just after nRE falls, and the block captures the lane t_strobe+1 clocks later. rb_status lags nf_rb by two edges, which is why the model holds busy for at least eight clocks. Stream bytes are taken at the falling edge just before the handshaking rising edge. Sequence, count and data checks run only after op_busy has dropped.

// File: rtl/nand_page_reader.sv
module nand_page_reader #(
  parameter int PAGE_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int ID_BYTES    = 5,
  parameter int TW          = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_en,
  input  logic          ce_release,
  input  logic [TW-1:0] t_setup,
  input  logic [TW-1:0] t_strobe,
  input  logic [TW-1:0] t_hold,
  input  logic          req_valid,
  input  logic          req_id,
  input  logic [27:0]   req_addr,
  output logic          req_ready,
  output logic          op_busy,
  output logic          rb_status,
  output logic [7:0]    dout_data,
  output logic          dout_valid,
  input  logic          dout_ready,
  output logic [7:0]    nf_io_out,
  output logic          nf_io_oe,
  input  logic [7:0]    nf_io_in,
  output logic          nf_cle,
  output logic          nf_ale,
  output logic          nf_ce_n,
  output logic          nf_we_n,
  output logic          nf_re_n,
  input  logic          nf_rb
);
  localparam int RD_TOTAL = PAGE_BYTES + SPARE_BYTES;
  localparam int CW = $clog2(RD_TOTAL + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_RBLO, S_RBHI, S_OUT} st_t;

  st_t           st;
  logic [TW-1:0] tcnt;
  logic [2:0]    step;
  logic          rd, id_q, rb_m, rb_s;
  logic [27:0]   addr_q;
  logic [CW-1:0] bcnt;
  logic [7:0]    data_q;

  logic       seq_cle, last_step, keep, last_byte, on_bus;
  logic [7:0] seq_byte;

  always_comb begin
    seq_cle   = 1'b0;
    seq_byte  = 8'h00;
    last_step = 1'b0;
    if (id_q) begin
      seq_cle   = (step == 3'd0);
      seq_byte  = (step == 3'd0) ? 8'h90 : 8'h00;
      last_step = (step == 3'd1);
    end else begin
      case (step)
        3'd0: seq_cle = 1'b1;
        3'd1: seq_byte = addr_q[7:0];
        3'd2: seq_byte = {5'b0, addr_q[10:8]};
        3'd3: seq_byte = addr_q[18:11];
        3'd4: seq_byte = addr_q[26:19];
        3'd5: seq_byte = {7'b0, addr_q[27]};
        default: begin seq_cle = 1'b1; seq_byte = 8'h30; end
      endcase
      last_step = (step == 3'd6);
    end
  end

  assign keep      = id_q || (bcnt < CW'(PAGE_BYTES));
  assign last_byte = bcnt == (id_q ? CW'(ID_BYTES - 1) : CW'(RD_TOTAL - 1));
  assign on_bus    = (st == S_SETUP) || (st == S_STROBE) || (st == S_HOLD);

  assign req_ready  = (st == S_IDLE) && ctl_en;
  assign op_busy    = (st != S_IDLE);
  assign rb_status  = rb_s;
  assign dout_valid = (st == S_OUT);
  assign dout_data  = data_q;
  assign nf_io_oe   = on_bus && !rd;
  assign nf_io_out  = seq_byte;
  assign nf_cle     = on_bus && !rd && seq_cle;
  assign nf_ale     = on_bus && !rd && !seq_cle;
  assign nf_ce_n    = ce_release;
  assign nf_we_n    = !((st == S_STROBE) && !rd);
  assign nf_re_n    = !((st == S_STROBE) && rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tcnt   <= '0;
      step   <= '0;
      rd     <= 1'b0;
      id_q   <= 1'b0;
      addr_q <= '0;
      bcnt   <= '0;
      data_q <= '0;
      rb_m   <= 1'b1;
      rb_s   <= 1'b1;
    end else begin
      rb_m <= nf_rb;
      rb_s <= rb_m;
      case (st)
        S_IDLE: if (req_valid && req_ready) begin
          id_q   <= req_id;
          addr_q <= req_addr;
          step   <= '0;
          rd     <= 1'b0;
          bcnt   <= '0;
          if (t_setup == '0) begin st <= S_STROBE; tcnt <= t_strobe; end
          else begin st <= S_SETUP; tcnt <= t_setup - TW'(1); end
        end
        S_SETUP:
          if (tcnt == '0) begin st <= S_STROBE; tcnt <= t_strobe; end
          else tcnt <= tcnt - TW'(1);
        S_STROBE:
          if (tcnt == '0) begin
            st   <= S_HOLD;
            tcnt <= t_hold;
            if (rd) data_q <= nf_io_in;
          end else tcnt <= tcnt - TW'(1);
        S_HOLD:
          if (tcnt != '0) tcnt <= tcnt - TW'(1);
          else if (rd) begin
            if (keep) st <= S_OUT;
            else if (last_byte) st <= S_IDLE;
            else begin bcnt <= bcnt + CW'(1); st <= S_STROBE; tcnt <= t_strobe; end
          end else if (!last_step) begin
            step <= step + 3'd1;
            if (t_setup == '0) begin st <= S_STROBE; tcnt <= t_strobe; end
            else begin st <= S_SETUP; tcnt <= t_setup - TW'(1); end
          end else if (id_q) begin
            rd <= 1'b1; st <= S_STROBE; tcnt <= t_strobe;
          end else st <= S_RBLO;
        S_RBLO: if (!rb_s) st <= S_RBHI;
        S_RBHI: if (rb_s) begin rd <= 1'b1; st <= S_STROBE; tcnt <= t_strobe; end
        S_OUT: if (dout_ready) begin
          if (last_byte) st <= S_IDLE;
          else begin bcnt <= bcnt + CW'(1); st <= S_STROBE; tcnt <= t_strobe; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [TW:0] we_lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_lo_cnt <= '0;
    else if (!nf_we_n) we_lo_cnt <= we_lo_cnt + (TW+1)'(1);
    else we_lo_cnt <= '0;
  end

  p_lane_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n && $past(!nf_we_n)) |-> ($stable(nf_io_out) && $stable(nf_cle) && $stable(nf_ale)));

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) |-> (we_lo_cnt == {1'b0, t_strobe} + (TW+1)'(1)));

  p_read_when_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_re_n) |-> rb_s);

  p_stream_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

  p_accept_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_busy) |-> $past(req_valid && req_ready));
endmodule

// File: tb/nand_page_reader_bench.sv
module nand_page_reader_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, ctl_en = 1'b1, ce_release = 1'b0;
  logic [3:0] t_setup = 4'd1, t_strobe = 4'd1, t_hold = 4'd1;
  logic req_valid = 1'b0, req_id = 1'b0;
  logic [27:0] req_addr = '0;
  logic req_ready, op_busy, rb_status, dout_valid, nf_io_oe, nf_cle, nf_ale, nf_ce_n, nf_we_n, nf_re_n;
  logic [7:0] dout_data, nf_io_out;
  logic dout_ready = 1'b1;
  logic [7:0] nf_io_in = 8'h00;
  logic nf_rb = 1'b1;

  nand_page_reader u_nand_page_reader (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ce_release(ce_release),
    .t_setup(t_setup), .t_strobe(t_strobe), .t_hold(t_hold),
    .req_valid(req_valid), .req_id(req_id), .req_addr(req_addr),
    .req_ready(req_ready), .op_busy(op_busy), .rb_status(rb_status),
    .dout_data(dout_data), .dout_valid(dout_valid), .dout_ready(dout_ready),
    .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_ce_n(nf_ce_n),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_rb(nf_rb));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int cyc = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] page_byte(logic [27:0] a, int i);
    if (i < 2048) return 8'(i) ^ (8'(i >> 8) * 8'd37) ^ a[7:0] ^ a[26:19];
    return 8'hA5 ^ 8'(i);
  endfunction

  function automatic logic [7:0] id_byte(int k);
    case (k)
      0: return 8'h2C;
      1: return 8'hDC;
      2: return 8'h90;
      3: return 8'h95;
      default: return 8'h56;
    endcase
  endfunction

  function automatic logic [9:0] exp_wr(bit id, logic [27:0] a, int k);
    if (id) return (k == 0) ? {2'b10, 8'h90} : {2'b01, 8'h00};
    case (k)
      0: return {2'b10, 8'h00};
      1: return {2'b01, a[7:0]};
      2: return {2'b01, 5'b0, a[10:8]};
      3: return {2'b01, a[18:11]};
      4: return {2'b01, a[26:19]};
      5: return {2'b01, 7'b0, a[27]};
      default: return {2'b10, 8'h30};
    endcase
  endfunction

  logic [9:0] log_w [0:15];
  int log_n = 0, cmd30_n = 0, cmd30_seen = 0, busy_left = 0, rd_idx = 0, early = 0;
  logic [7:0] last_cmd = 8'h00;
  logic [27:0] tb_addr = '0;

  always @(posedge nf_we_n) if (rst_n === 1'b1) begin
    if (log_n < 16) log_w[log_n] = {nf_cle, nf_ale, nf_io_out};
    log_n++;
    if (nf_cle) begin
      last_cmd = nf_io_out;
      if (nf_io_out == 8'h30) cmd30_n++;
    end
  end

  always @(negedge clk) begin
    if (cmd30_n != cmd30_seen) begin
      cmd30_seen = cmd30_n;
      busy_left = 8 + int'($urandom % 24);
    end else if (busy_left > 0) busy_left--;
    nf_rb = (busy_left == 0);
  end

  always @(negedge nf_re_n) if (rst_n === 1'b1) begin
    if (!nf_rb) early++;
    nf_io_in = (last_cmd == 8'h90) ? id_byte(rd_idx) : page_byte(tb_addr, rd_idx);
  end
  always @(posedge nf_re_n) if (rst_n === 1'b1) rd_idx++;

  bit rand_rdy = 1'b0;
  logic [7:0] got [0:2047];
  int got_n = 0;
  always @(negedge clk) begin
    dout_ready = rand_rdy ? (($urandom % 4) != 0) : 1'b1;
    if (rst_n && dout_valid && dout_ready) begin
      if (got_n < 2048) got[got_n] = dout_data;
      got_n++;
    end
  end

  logic grp_prev = 1'b0, we_prev = 1'b1, re_prev = 1'b1, grp;
  int we_lo = 0, re_lo = 0, pre = 0, post = 0, terr = 0, bus_err = 0;
  bit first = 1'b0, stat_low = 1'b0;
  always @(negedge clk) if (rst_n) begin
    grp = nf_cle | nf_ale;
    if (grp && !grp_prev) begin first = 1'b1; pre = 0; post = 0; end
    if (!nf_we_n) begin
      if (we_prev) begin
        if (first) begin if (pre != int'(t_setup)) terr++; first = 1'b0; end
        else if (post != int'(t_hold) + 1 + int'(t_setup)) terr++;
      end
      we_lo++;
    end else begin
      if (!we_prev) begin
        if (we_lo != int'(t_strobe) + 1) terr++;
        we_lo = 0; post = 0;
      end
      if (grp) begin if (first) pre++; else post++; end
    end
    if (!grp && grp_prev && post != int'(t_hold) + 1) terr++;
    if (!nf_re_n) begin
      if (re_prev && re_lo != 0 && re_lo < int'(t_hold) + 1) terr++;
      if (re_prev) re_lo = 0;
      re_lo++;
    end else begin
      if (!re_prev) begin
        if (re_lo != int'(t_strobe) + 1) terr++;
        re_lo = 0;
      end
      re_lo++;
    end
    if (nf_io_oe && !grp) bus_err++;
    if (nf_cle && nf_ale) bus_err++;
    if (op_busy && !rb_status) stat_low = 1'b1;
    grp_prev = grp; we_prev = nf_we_n; re_prev = nf_re_n;
  end

  task automatic run_op(bit id, logic [27:0] a, int ts, int tw, int th, bit rr, bit poke);
    int cnt, mis, nw, nd, nr;
    @(negedge clk);
    t_setup = 4'(ts); t_strobe = 4'(tw); t_hold = 4'(th);
    tb_addr = a; rand_rdy = rr;
    log_n = 0; got_n = 0; rd_idx = 0; terr = 0; bus_err = 0; early = 0;
    stat_low = 1'b0; last_cmd = 8'h00; re_lo = 0;
    req_id = id; req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(op_busy, "R10", "request taken", int'(op_busy), 1);
    cnt = 0;
    while (op_busy && cnt < 100000) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 20) begin
        req_valid = 1'b1; req_id = 1'b1;
        check(!req_ready, "R10", "req_ready while busy", int'(req_ready), 0);
      end
      if (poke && cnt == 24) req_valid = 1'b0;
    end
    req_valid = 1'b0;
    nw = id ? 2 : 7;
    nd = id ? 5 : 2048;
    nr = id ? 5 : 2112;
    check(log_n == nw, id ? "R8" : "R3", "write byte count", log_n, nw);
    mis = 0;
    for (int k = 0; k < nw && k < 16; k++)
      if (log_w[k] !== exp_wr(id, a, k)) begin
        if (mis == 0) $display("FAIL %s write %0d: actual %h expected %h", id ? "R8" : "R3",
                               k, log_w[k], exp_wr(id, a, k));
        mis++;
      end
    check(mis == 0, id ? "R8" : "R3", "write byte mismatches", mis, 0);
    check(got_n == nd, id ? "R8" : "R6", "stream byte count", got_n, nd);
    mis = 0;
    for (int k = 0; k < nd && k < got_n; k++)
      if (got[k] !== (id ? id_byte(k) : page_byte(a, k))) mis++;
    check(mis == 0, id ? "R8" : "R6", "stream data mismatches", mis, 0);
    check(rd_idx == nr, "R7", "read strobe count", rd_idx, nr);
    check(terr == 0, "R4", "timing violations", terr, 0);
    check(bus_err == 0, "R2", "lane/latch violations", bus_err, 0);
    if (!id) begin
      check(early == 0, "R5", "reads before ready", early, 0);
      check(stat_low, "R5", "busy seen on rb_status", int'(stat_low), 1);
    end
    check(rb_status, "R5", "rb_status ready at idle", int'(rb_status), 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(nf_we_n && nf_re_n, "R1", "strobes idle high", int'({nf_we_n, nf_re_n}), 3);
    check(!nf_cle && !nf_ale && !nf_io_oe, "R1", "latches/lane idle", int'({nf_cle, nf_ale, nf_io_oe}), 0);
    check(!dout_valid && !op_busy, "R1", "no valid, not busy", int'({dout_valid, op_busy}), 0);
    check(req_ready == ctl_en, "R1", "req_ready follows ctl_en", int'(req_ready), 1);
    check(nf_ce_n == 1'b0, "R11", "nCE low with ce_release=0", int'(nf_ce_n), 0);
    ce_release = 1'b1;
    @(negedge clk);
    check(nf_ce_n == 1'b1, "R11", "nCE high with ce_release=1", int'(nf_ce_n), 1);
    ce_release = 1'b0;

    ctl_en = 1'b0; log_n = 0;
    @(negedge clk);
    check(!req_ready, "R9", "req_ready with ctl_en=0", int'(req_ready), 0);
    req_valid = 1'b1; req_id = 1'b0;
    repeat (6) @(negedge clk);
    req_valid = 1'b0;
    check(!op_busy && log_n == 0 && nf_we_n, "R9", "bus quiet when disabled", log_n, 0);
    ctl_en = 1'b1;
    @(negedge clk);

    run_op(1'b1, 28'h0, 15, 15, 15, 1'b0, 1'b0);
    run_op(1'b1, 28'h0, 0, 0, 0, 1'b1, 1'b0);
    run_op(1'b0, 28'h0000000, 0, 0, 0, 1'b0, 1'b0);
    run_op(1'b0, 28'hFFFFFFF, 1, 2, 1, 1'b1, 1'b0);
    run_op(1'b0, 28'h5A3C7E1, 1, 1, 1, 1'b1, 1'b1);
    for (int r = 0; r < 2; r++) begin
      s = int'($urandom);
      run_op(1'b0, 28'($urandom), s % 4, (s >> 4) % 4, (s >> 8) % 4, 1'b1, 1'b0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule